// File: doc/BRIEF.md
# Sleep-Triggered Clock Source Controller

This block sequences the power mode and the system clock source of a small microcontroller core. Software writes a control byte that holds a clock-change-enable flag and a PLL-select flag. When the core executes its sleep instruction, a one-cycle strobe reaches the block. The block then combines that strobe with a standby-enable level and a low-speed-select level. From these it decides to do one of three things: idle in sleep mode, park in standby or watch mode until a wake-up event, or move straight to a new clock source.

Three sources can be selected: the main clock, the 24 MHz PLL clock and the 32 kHz subclock. Every change of the select code is wrapped in a break-before-make sequence. The clock enable goes low, the select code changes while the clock is gated, and the enable returns only after a programmable gap. A switch to the PLL clock waits for the PLL-locked input. When the block wakes from standby or watch mode, it first counts an oscillator settling interval given at a port, and only then releases the clock.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: After reset, `reg_rdata` is 0x00, `clk_sel` is 0 (main clock), `clk_en` is 1 and `mode` is 0 (active).
- R2: A write sets bit 2 (clock-change enable) and bit 0 (PLL select) of the control byte. Every other bit reads back as 0, whatever value was written.
- R3: A sleep strobe with `stby_en` at 0 sets `mode` to 1 (sleep) and leaves `clk_sel` and `clk_en` unchanged. A wake event then returns `mode` to 0 on the next cycle.
- R4: A sleep strobe with `stby_en` at 1 and clock-change enable at 0 sets `clk_en` to 0 and keeps `clk_sel`. `mode` then reads 3 (watch) if the target is the subclock and 2 (standby) otherwise, and the block stays there until a wake event.
- R5: After a wake event in standby or watch mode, `mode` stays at 2 or 3 for `settle_cnt`+1 cycles. The block then switches to the target source and returns to `mode` 0 with `clk_en` at 1.
- R6: A sleep strobe with `stby_en` at 1 and clock-change enable at 1 sets `mode` to 4 (switching) and never passes through 2 or 3. The block ends in `mode` 0 on the target source.
- R7: The target source is 0 (main) when PLL select is 0 and 1 (PLL) when PLL select is 1. `lowspd_sel` at 1 overrides both and selects 2 (subclock).
- R8: While the target is the PLL and `pll_locked` is 0, a direct switch holds in `mode` 4 with `clk_sel` and `clk_en` unchanged. It completes once `pll_locked` rises.
- R9: `clk_sel` changes only in a cycle where `clk_en` is 0, and only if `clk_en` was also 0 in the cycle before. `clk_en` rises only while `clk_sel` is stable.
- R10: While running on the subclock (`clk_sel` 2), a sleep strobe enters sleep mode (`mode` 1) even with `stby_en` at 1. No clock switch takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte read data |
| sleep_req | input | 1 | One-cycle sleep-instruction strobe |
| stby_en | input | 1 | Standby enable level |
| lowspd_sel | input | 1 | Low-speed (subclock) select level |
| pll_locked | input | 1 | PLL running and stable |
| wake_evt | input | 1 | Wake-up event |
| settle_cnt | input | SETTLE_W | Oscillator settling count in cycles |
| clk_sel | output | 2 | Clock source select: 0 main, 1 PLL, 2 subclock |
| clk_en | output | 1 | System clock gate enable |
| mode | output | 3 | 0 active, 1 sleep, 2 standby, 3 watch, 4 switching |

## Verification
The sleep strobe is applied under each combination of standby enable, clock-change enable, PLL select and low-speed select that leads to a distinct outcome. Together these cases tell plain sleep apart from standby, watch and direct switching, and show that the low-speed select wins over the PLL select. A run with the PLL unlocked separates a deferred switch from an immediate one. Timing the mode after a wake event separates a correct settling interval from one that is short by a cycle. A continuous monitor on the select and enable outputs catches any select change made while the clock was enabled.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
    typedef enum logic [1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SUB  = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        MD_ACTIVE = 3'd0,
        MD_SLEEP  = 3'd1,
        MD_STBY   = 3'd2,
        MD_WATCH  = 3'd3,
        MD_SWITCH = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ST_RUN, ST_SLEEP, ST_STBY, ST_SETTLE, ST_WAITPLL, ST_BREAK, ST_MAKE
    } st_e;

    localparam int unsigned CCE_BIT = 2;
    localparam int unsigned PLS_BIT = 0;
endpackage

// File: rtl/sclk_cfg_reg.sv
module sclk_cfg_reg
    import sclk_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic          cce,
    output logic          pll_sel,
    output logic [DW-1:0] rdata
);
    typedef struct packed {
        logic cce;
        logic pls;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.cce = wdata[CCE_BIT];
            cfg_d.pls = wdata[PLS_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rdata          = '0;
        rdata[CCE_BIT] = cfg_q.cce;
        rdata[PLS_BIT] = cfg_q.pls;
    end

    assign cce     = cfg_q.cce;
    assign pll_sel = cfg_q.pls;

    AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cce == $past(wdata[CCE_BIT]) && pll_sel == $past(wdata[PLS_BIT]))); // R2
endmodule

// File: rtl/sclk_src_pick.sv
module sclk_src_pick
    import sclk_pkg::*;
(
    input  logic lowspd_sel,
    input  logic pll_sel,
    output src_e tgt
);
    always_comb begin
        if (lowspd_sel)   tgt = SRC_SUB;
        else if (pll_sel) tgt = SRC_PLL;
        else              tgt = SRC_MAIN;
    end
endmodule

// File: rtl/sclk_seq.sv
module sclk_seq
    import sclk_pkg::*;
#(
    parameter int unsigned SETTLE_W = 8,
    parameter int unsigned GAP_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sleep_req,
    input  logic                stby_en,
    input  logic                cce,
    input  src_e                tgt_pick,
    input  logic                pll_locked,
    input  logic                wake_evt,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output src_e                clk_sel,
    output logic                clk_en,
    output mode_e               mode
);
    localparam int unsigned GW = $clog2(GAP_CYC + 1);
    localparam int unsigned CW = (SETTLE_W > GW) ? SETTLE_W : GW;
    localparam logic [CW-1:0] GAP_LAST = CW'(GAP_CYC - 1);

    typedef struct packed {
        st_e           st;
        src_e          sel;
        src_e          tgt;
        logic          en;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t q, d;
    logic [CW-1:0] settle_ext;

    assign settle_ext = CW'(settle_cnt);

    always_comb begin
        d = q;
        case (q.st)
            ST_RUN: if (sleep_req) begin
                if (!stby_en || q.sel == SRC_SUB) begin
                    d.st = ST_SLEEP;
                end else begin
                    d.tgt = tgt_pick;
                    if (cce) begin
                        d.st = ST_WAITPLL;
                    end else begin
                        d.st = ST_STBY;
                        d.en = 1'b0;
                    end
                end
            end
            ST_SLEEP: if (wake_evt) d.st = ST_RUN;
            ST_STBY: if (wake_evt) begin
                d.st  = ST_SETTLE;
                d.cnt = '0;
            end
            ST_SETTLE: begin
                if (q.cnt >= settle_ext) d.st = ST_WAITPLL;
                else                     d.cnt = q.cnt + 1'b1;
            end
            ST_WAITPLL: if (q.tgt != SRC_PLL || pll_locked) begin
                d.st  = ST_BREAK;
                d.en  = 1'b0;
                d.cnt = '0;
            end
            ST_BREAK: begin
                if (q.cnt == GAP_LAST) begin
                    d.sel = q.tgt;
                    d.st  = ST_MAKE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_MAKE: begin
                if (q.cnt == GAP_LAST) begin
                    d.en = 1'b1;
                    d.st = ST_RUN;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_RUN;
            q.sel <= SRC_MAIN;
            q.tgt <= SRC_MAIN;
            q.en  <= 1'b1;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (q.st)
            ST_RUN:              mode = MD_ACTIVE;
            ST_SLEEP:            mode = MD_SLEEP;
            ST_STBY, ST_SETTLE:  mode = (q.tgt == SRC_SUB) ? MD_WATCH : MD_STBY;
            default:             mode = MD_SWITCH;
        endcase
    end

    assign clk_sel = q.sel;
    assign clk_en  = q.en;

    AST_SEL_ONLY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.sel) |-> (!q.en && !$past(q.en))); // R9
    AST_EN_RISE_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.en) |-> ($stable(q.sel) && q.st == ST_RUN)); // R9
    AST_STBY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_STBY || q.st == ST_SETTLE) |-> !q.en); // R4
    AST_SLEEP_KEEPS_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SLEEP) |-> (q.en && $stable(q.sel))); // R3
    AST_PLL_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WAITPLL && q.tgt == SRC_PLL && !pll_locked)
            |=> (q.st == ST_WAITPLL && $stable(q.sel) && $stable(q.en))); // R8
endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
    import sclk_pkg::*;
#(
    parameter int unsigned SETTLE_W = 8,
    parameter int unsigned GAP_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic                sleep_req,
    input  logic                stby_en,
    input  logic                lowspd_sel,
    input  logic                pll_locked,
    input  logic                wake_evt,
    input  logic [SETTLE_W-1:0] settle_cnt,
    output logic [1:0]          clk_sel,
    output logic                clk_en,
    output logic [2:0]          mode
);
    logic  cce_w;
    logic  pls_w;
    src_e  tgt_w;
    src_e  sel_w;
    mode_e mode_w;

    sclk_cfg_reg #(.DW(8)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wdata   (reg_wdata),
        .cce     (cce_w),
        .pll_sel (pls_w),
        .rdata   (reg_rdata)
    );

    sclk_src_pick u_pick (
        .lowspd_sel (lowspd_sel),
        .pll_sel    (pls_w),
        .tgt        (tgt_w)
    );

    sclk_seq #(.SETTLE_W(SETTLE_W), .GAP_CYC(GAP_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .stby_en    (stby_en),
        .cce        (cce_w),
        .tgt_pick   (tgt_w),
        .pll_locked (pll_locked),
        .wake_evt   (wake_evt),
        .settle_cnt (settle_cnt),
        .clk_sel    (sel_w),
        .clk_en     (clk_en),
        .mode       (mode_w)
    );

    assign clk_sel = sel_w;
    assign mode    = mode_w;
endmodule

// File: tb/tb_sleep_clk_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_clk_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       sleep_req = 1'b0;
    logic       stby_en = 1'b0;
    logic       lowspd_sel = 1'b0;
    logic       pll_locked = 1'b0;
    logic       wake_evt = 1'b0;
    logic [7:0] settle_cnt = '0;
    logic [1:0] clk_sel;
    logic       clk_en;
    logic [2:0] mode;

    int n_chk = 0;
    int n_bad = 0;
    int bbm_bad = 0;
    logic [1:0] prev_sel = 2'd0;
    logic       prev_en = 1'b1;
    logic       done = 1'b0;

    always #2.5 clk = ~clk;

    sleep_clk_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_req(sleep_req), .stby_en(stby_en),
        .lowspd_sel(lowspd_sel), .pll_locked(pll_locked), .wake_evt(wake_evt),
        .settle_cnt(settle_cnt), .clk_sel(clk_sel), .clk_en(clk_en), .mode(mode)
    );

    // R9 monitor: select must move only while gated now and in the previous cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (clk_sel != prev_sel && (clk_en || prev_en)) bbm_bad++;
            prev_sel = clk_sel;
            prev_en  = clk_en;
        end else begin
            prev_sel = 2'd0;
            prev_en  = 1'b1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; sleep_req = 0; wake_evt = 0; reg_wr = 0;
        stby_en = 0; lowspd_sel = 0; pll_locked = 1; settle_cnt = 8'd3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake_evt = 1'b1;
        @(negedge clk); wake_evt = 1'b0;
    endtask

    task automatic wait_active();
        for (int i = 0; i < 300 && mode != 3'd0; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 clk_en", clk_en, 1);
        chk("R1 mode", mode, 0);
    endtask

    task automatic t_reg();
        do_reset();
        wr(8'hFF);
        chk("R2 write all ones", reg_rdata, 8'h05);
        wr(8'h1A);
        chk("R2 reserved bits only", reg_rdata, 8'h00);
    endtask

    task automatic t_sleep();
        do_reset();
        stby_en = 1'b0;
        wr(8'h01);
        pulse_sleep();
        chk("R3 mode sleep", mode, 1);
        chk("R3 sel kept", clk_sel, 0);
        chk("R3 en kept", clk_en, 1);
        repeat (5) @(negedge clk);
        chk("R3 still sleep", mode, 1);
        pulse_wake();
        chk("R3 wake to active", mode, 0);
        chk("R3 sel after wake", clk_sel, 0);
    endtask

    task automatic t_standby_pll();
        int n;
        do_reset();
        settle_cnt = 8'd6;
        stby_en = 1'b1; pll_locked = 1'b1;
        wr(8'h01);
        pulse_sleep();
        chk("R4 mode standby", mode, 2);
        chk("R4 clock gated", clk_en, 0);
        chk("R4 sel kept", clk_sel, 0);
        repeat (10) @(negedge clk);
        chk("R4 holds until wake", mode, 2);
        pulse_wake();
        n = 0;
        while (mode == 3'd2 && n < 1000) begin n++; @(negedge clk); end
        chk("R5 settle cycles", n, 7);
        wait_active();
        chk("R5 active after settle", mode, 0);
        chk("R7 pll target", clk_sel, 1);
        chk("R5 clock released", clk_en, 1);
    endtask

    task automatic t_watch_sub();
        do_reset();
        settle_cnt = 8'd2;
        stby_en = 1'b1; lowspd_sel = 1'b1;
        wr(8'h01);
        pulse_sleep();
        chk("R4 mode watch", mode, 3);
        chk("R4 watch gated", clk_en, 0);
        pulse_wake();
        wait_active();
        chk("R7 low-speed wins", clk_sel, 2);
        lowspd_sel = 1'b0;
        pulse_sleep();
        chk("R10 sleep from subclock", mode, 1);
        repeat (10) @(negedge clk);
        chk("R10 no switch", clk_sel, 2);
        pulse_wake();
        chk("R10 wake", mode, 0);
    endtask

    task automatic t_direct();
        int seen_stby;
        do_reset();
        stby_en = 1'b1; pll_locked = 1'b1;
        wr(8'h05);
        pulse_sleep();
        chk("R6 mode switching", mode, 4);
        seen_stby = 0;
        for (int i = 0; i < 300 && mode != 3'd0; i++) begin
            if (mode == 3'd2 || mode == 3'd3) seen_stby = 1;
            @(negedge clk);
        end
        chk("R6 no standby pass", seen_stby, 0);
        chk("R6 active", mode, 0);
        chk("R6 pll selected", clk_sel, 1);
        wr(8'h04);
        pulse_sleep();
        wait_active();
        chk("R7 back to main", clk_sel, 0);
    endtask

    task automatic t_defer();
        do_reset();
        stby_en = 1'b1; pll_locked = 1'b0;
        wr(8'h05);
        pulse_sleep();
        repeat (20) @(negedge clk);
        chk("R8 holds switching", mode, 4);
        chk("R8 sel unchanged", clk_sel, 0);
        chk("R8 en unchanged", clk_en, 1);
        pll_locked = 1'b1;
        wait_active();
        chk("R8 switched after lock", clk_sel, 1);
        chk("R8 active", mode, 0);
    endtask

    initial begin
        t_reset();
        t_reg();
        t_sleep();
        t_standby_pll();
        t_watch_sub();
        t_direct();
        t_defer();
        chk("R9 break-before-make", bbm_bad, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule